// File: doc/BRIEF.md
# Four-Lane Serial-to-Parallel Pixel Deserializer

The block turns four serial data lanes back into one parallel pixel word. A fifth lane carries a framing clock that has been sampled as plain data. All logic runs on a bit clock at seven times the pixel rate, so one pixel period lasts seven bit-clock cycles. The block samples each lane once per bit-clock cycle, and each sample stands for one bit slot.

The framing lane is high for the first four slots of a period and low for the last three. The block searches a seven-bit window of that lane for this shape and confirms the phase over several periods before it declares lock. Once locked, it moves one 28-bit word to its output register per period, at a fixed slot. It also drives a pixel-rate clock whose falling edge falls in the middle of the valid data.

An active-low power-down input clears the lock and silences the outputs. While the block is unlocked, the word output is zero and the pixel clock stays low.

Top module: `serial_pixel_deser`

## Requirements
- R1: After reset, `word_o` is zero and `pix_clk_o` is low.
- R2: Each period carries seven slots. Slot k of a data lane holds word bit 1, 0, 6, 5, 4, 3, 2 for k = 0..6. Lane n supplies output bits 7n to 7n+6. The framing lane is 1 in slots 0..3 and 0 in slots 4..6.
- R3: Lock is declared after three consecutive framing windows equal 1111000 (oldest sample first) at the same phase. The first word delivered is the one from the fourth matching period.
- R4: Before lock, `word_o` stays zero and `pix_clk_o` never rises, whatever the data lanes carry.
- R5: While locked, one mismatched framing period is tolerated. The word of that period is still delivered.
- R6: Two consecutive mismatched periods drop the lock, force `word_o` to zero and `pix_clk_o` low. A new lock again takes three matches.
- R7: While locked, `pix_clk_o` is high for 4 bit cycles and low for 3. `word_o` changes only at the rising edge and holds across the falling edge.
- R8: While `pd_ni` is low, `word_o` is zero and `pix_clk_o` is low from the next bit-clock edge, and the lock is lost.
- R9: Lock and word recovery work at any start phase of the stream relative to reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven cycles per pixel period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_ni | input | 1 | Power-down, active low |
| lane_i | input | LANES | One sample per data lane per bit cycle |
| frame_i | input | 1 | Sampled framing-clock lane |
| word_o | output | LANES*SLOTS | Recovered parallel word |
| pix_clk_o | output | 1 | Pixel clock, falling edge strobes `word_o` |

## Verification
The bench builds the block with its default parameters: four lanes, seven slots, a lock threshold of three matches and an unlock threshold of two misses. With these short thresholds, lock, a tolerated miss, loss of lock and relock all fit inside one ten-period stream. Each stream starts at a different phase. A power-down pulse lands in the middle of a high pixel-clock phase, and the bench checks that the word delivered during that phase is kept and that the outputs are then silent.

// File: rtl/deser_pkg.sv
package deser_pkg;
  // Word bit carried by slot s of an n-slot period: two bits rotated ahead of MSB-first
  function automatic int slot_bit(int s, int n);
    return (s < 2) ? 1 - s : n + 1 - s;
  endfunction
endpackage

// File: rtl/deser_lane_shift.sv
module deser_lane_shift #(
  parameter int SLOTS = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             bit_i,
  output logic [SLOTS-1:0] sr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sr_o <= '0;
    else if (clr_i) sr_o <= '0;
    else            sr_o <= {sr_o[SLOTS-2:0], bit_i};
  end
endmodule

// File: rtl/deser_word_map.sv
module deser_word_map #(
  parameter int LANES = 4,
  parameter int SLOTS = 7
) (
  input  logic [LANES*SLOTS-1:0] sr_flat_i,
  output logic [LANES*SLOTS-1:0] word_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int B = deser_pkg::slot_bit(s, SLOTS);
      // oldest sample (slot 0) sits at the top of the shift register
      assign word_o[l*SLOTS + B] = sr_flat_i[l*SLOTS + SLOTS-1-s];
    end
  end
endmodule

// File: rtl/deser_frame_lock.sv
module deser_frame_lock #(
  parameter int SLOTS       = 7,
  parameter int LOCK_HITS   = 3,
  parameter int UNLOCK_MISS = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     frame_i,
  output logic                     boundary_o,
  output logic                     lock_o,
  output logic                     lock_nxt_o,
  output logic [$clog2(SLOTS)-1:0] ph_nxt_o
);
  localparam int PW = $clog2(SLOTS);
  localparam int HW = $clog2(LOCK_HITS + 1);
  localparam int MW = $clog2(UNLOCK_MISS + 1);
  localparam int HI = (SLOTS + 1) / 2;
  localparam logic [SLOTS-1:0] PAT = SLOTS'(((1 << HI) - 1) << (SLOTS - HI));

  logic [SLOTS-1:0] fsr;
  logic [PW-1:0]    ph_q;
  logic [HW-1:0]    hits_q, hits_n;
  logic [MW-1:0]    miss_q, miss_n;
  logic             match;

  deser_lane_shift #(.SLOTS(SLOTS)) u_fsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!en_i), .bit_i(frame_i), .sr_o(fsr)
  );

  assign match      = (fsr == PAT);
  assign boundary_o = (ph_q == PW'(SLOTS-1));

  always_comb begin
    ph_nxt_o   = boundary_o ? '0 : ph_q + 1'b1;
    hits_n     = hits_q;
    miss_n     = miss_q;
    lock_nxt_o = lock_o;
    if (!en_i) begin
      ph_nxt_o = '0; hits_n = '0; miss_n = '0; lock_nxt_o = 1'b0;
    end else if (!lock_o) begin
      if (match) begin
        ph_nxt_o = '0;  // realign phase on any hit
        hits_n = (boundary_o && hits_q != '0) ? hits_q + 1'b1 : HW'(1);
        if (hits_n == HW'(LOCK_HITS)) begin
          lock_nxt_o = 1'b1; hits_n = '0; miss_n = '0;
        end
      end else if (boundary_o) begin
        hits_n = '0;
      end
    end else if (boundary_o) begin
      if (match) miss_n = '0;
      else begin
        miss_n = miss_q + 1'b1;
        if (miss_n == MW'(UNLOCK_MISS)) begin
          lock_nxt_o = 1'b0; miss_n = '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0; hits_q <= '0; miss_q <= '0; lock_o <= 1'b0;
    end else begin
      ph_q <= ph_nxt_o; hits_q <= hits_n; miss_q <= miss_n; lock_o <= lock_nxt_o;
    end
  end

  AST_LOCK_NEEDS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(match && en_i));  // R3
  AST_UNLOCK_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> $past(!match || !en_i));  // R6
  AST_PD_DROPS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !lock_o);  // R8
endmodule

// File: rtl/serial_pixel_deser.sv
module serial_pixel_deser #(
  parameter int LANES       = 4,
  parameter int SLOTS       = 7,
  parameter int LOCK_HITS   = 3,
  parameter int UNLOCK_MISS = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pd_ni,
  input  logic [LANES-1:0]       lane_i,
  input  logic                   frame_i,
  output logic [LANES*SLOTS-1:0] word_o,
  output logic                   pix_clk_o
);
  localparam int W  = LANES * SLOTS;
  localparam int PW = $clog2(SLOTS);
  localparam int HI = (SLOTS + 1) / 2;

  logic [W-1:0]  sr_flat, mapped;
  logic [PW-1:0] ph_nxt;
  logic          boundary, locked, lock_nxt, cap, live_q, live_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    deser_lane_shift #(.SLOTS(SLOTS)) u_sr (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!pd_ni),
      .bit_i(lane_i[l]), .sr_o(sr_flat[l*SLOTS +: SLOTS])
    );
  end

  deser_frame_lock #(.SLOTS(SLOTS), .LOCK_HITS(LOCK_HITS), .UNLOCK_MISS(UNLOCK_MISS)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(pd_ni), .frame_i(frame_i),
    .boundary_o(boundary), .lock_o(locked), .lock_nxt_o(lock_nxt), .ph_nxt_o(ph_nxt)
  );

  deser_word_map #(.LANES(LANES), .SLOTS(SLOTS)) u_map (
    .sr_flat_i(sr_flat), .word_o(mapped)
  );

  assign cap    = locked && boundary;
  // pixel clock starts only once a real word sits in the output register
  assign live_n = lock_nxt && (live_q || cap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0; pix_clk_o <= 1'b0; live_q <= 1'b0;
    end else begin
      live_q    <= live_n;
      pix_clk_o <= live_n && (ph_nxt < PW'(HI));
      if (!lock_nxt) word_o <= '0;
      else if (cap)  word_o <= mapped;
    end
  end

  AST_PD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> (word_o == '0 && !pix_clk_o));  // R8
  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_clk_o && $past(pix_clk_o)) |-> $stable(word_o));  // R7
  AST_HOLD_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pix_clk_o) && $past(pd_ni)) |-> $stable(word_o));  // R7
  AST_QUIET_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked |-> (word_o == '0 && !pix_clk_o));  // R4
endmodule

// File: tb/tb_serial_pixel_deser.sv
`timescale 1ns/1ps
module tb_serial_pixel_deser;
  logic        clk = 1'b0, rst_ni = 1'b0, pd_ni = 1'b1, frame_i = 1'b0;
  logic [3:0]  lane_i = '0;
  logic [27:0] word_o;
  logic        pix_clk_o;

  serial_pixel_deser dut (.clk_i(clk), .rst_ni(rst_ni), .pd_ni(pd_ni), .lane_i(lane_i),
                          .frame_i(frame_i), .word_o(word_o), .pix_clk_o(pix_clk_o));

  always #10 clk = ~clk;

  localparam logic [27:0] VEC [10] = '{
    28'h8F3A1C5, 28'h0000001, 28'hFFFFFFF, 28'h5A5A5A5, 28'hA5A5A5A,
    28'h1234567, 28'h7654321, 28'h0C0FFEE, 28'hDEADBEE, 28'h8000000};

  int checks = 0, fails = 0, n = 0;
  logic [27:0] got [16];
  logic        prev_pclk = 1'b0, pd_seen = 1'b1, had_rise = 1'b0;
  logic [27:0] prev_word = '0;
  int          hi_run = 0, lo_run = 100;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int bit_of_slot(int s);
    return (s == 0) ? 1 : (s == 1) ? 0 : 8 - s;
  endfunction

  always @(posedge clk) pd_seen <= pd_ni;

  always @(negedge clk) if (rst_ni) begin
    if (pix_clk_o) begin
      if (prev_pclk) chk(word_o == prev_word, "R7", "word moved while clock high", word_o, prev_word);
      else begin
        if (had_rise && lo_run < 8) chk(lo_run == 3, "R7", "low run", lo_run, 3);
        had_rise = 1'b1; hi_run = 0;
      end
      hi_run++;
    end else begin
      if (prev_pclk) begin
        if (n < 16) got[n] = prev_word;
        n++;
        if (pd_seen) chk(hi_run == 4, "R7", "high run", hi_run, 4);
        lo_run = 0;
      end
      lo_run++;
    end
    prev_pclk = pix_clk_o;
    prev_word = word_o;
  end

  task automatic stream(int phase, int m1, int m2, int pd_f);
    n = 0;
    for (int i = 0; i < phase; i++) begin
      @(negedge clk); frame_i = 1'b0; lane_i = 4'($urandom);
    end
    for (int f = 0; f < 10; f++) begin
      for (int s = 0; s < 7; s++) begin
        @(negedge clk);
        pd_ni = !(pd_f >= 0 && ((f == pd_f && s >= 3) || f == pd_f + 1));
        frame_i = (f == m1 || f == m2) ? 1'b1 : (s < 4);
        for (int l = 0; l < 4; l++) lane_i[l] = VEC[f][l*7 + bit_of_slot(s)];
        if (pd_f >= 0 && f == pd_f + 1 && s == 3) begin
          chk(word_o == '0, "R8", "word during power-down", word_o, 0);
          chk(!pix_clk_o, "R8", "clock during power-down", pix_clk_o, 0);
        end
      end
    end
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); pd_ni = 1'b1; frame_i = 1'b0; lane_i = '0;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(word_o == '0, "R1", "word in reset", word_o, 0);
    chk(!pix_clk_o, "R1", "clock in reset", pix_clk_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(word_o == '0 && !pix_clk_o, "R1", "outputs after reset", {word_o, pix_clk_o}, 0);

    // R4: busy data lanes, framing lane stuck low then high
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); lane_i = 4'($urandom); frame_i = (i >= 20);
    end
    @(negedge clk);
    chk(n == 0, "R4", "clock pulses without lock", n, 0);
    chk(word_o == '0, "R4", "word without lock", word_o, 0);

    // R2 R3 R9: clean stream, phase 0
    stream(0, -1, -1, -1);
    chk(n == 8, "R3", "words delivered", n, 8);
    for (int k = 0; k < 7; k++) chk(got[k] == VEC[k+3], "R2", "word value", got[k], VEC[k+3]);
    chk(got[7] == '0, "R5", "word from first missed period", got[7], 0);
    chk(word_o == '0 && !pix_clk_o, "R6", "quiet after stream ends", {word_o, pix_clk_o}, 0);

    // R5 R9: single miss at period 5, phase 5
    stream(5, 5, -1, -1);
    chk(n == 8, "R5", "words with one miss", n, 8);
    for (int k = 0; k < 7; k++) chk(got[k] == VEC[k+3], "R5", "word value", got[k], VEC[k+3]);

    // R6: two misses drop lock, three matches relock
    stream(2, 5, 6, -1);
    chk(n == 4, "R6", "words with two misses", n, 4);
    for (int k = 0; k < 3; k++) chk(got[k] == VEC[k+3], "R6", "word value", got[k], VEC[k+3]);
    chk(got[3] == '0, "R6", "word after relock", got[3], 0);

    // R8 R9: power-down mid high phase, phase 1
    stream(1, -1, -1, 6);
    chk(n == 3, "R8", "words around power-down", n, 3);
    for (int k = 0; k < 3; k++) chk(got[k] == VEC[k+3], "R8", "word value", got[k], VEC[k+3]);
    chk(word_o == '0 && !pix_clk_o, "R8", "no relock after two matches", {word_o, pix_clk_o}, 0);

    finish_run();
  end
endmodule